// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block sits between a serial receiver core and the host side of a UART. Every character that the receiver core finishes is written, together with its parity-error and framing-error tags, into a 64-entry first-in first-out queue. The host sees the oldest entry and its tags at the head ports. It removes that entry with a one-cycle pop strobe.

The block tracks how many stored entries carry any error tag. A single summary flag is high exactly while at least one such entry is still queued, so the host can tell whether any error is waiting without walking the queue. The flag stays correct when writes and reads happen in the same cycle.

The block also watches the raw serial line. If the line stays low for a full character time (ten bit-time ticks, counted from the first tick that samples it low), the block flags a line break. It then enqueues one zero-valued character marked as a break. A live break indication stays high until the line returns high. Bit sampling and baud-rate generation belong to other blocks.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty (`fillLevel` 0, `empty` 1, `full` 0), and `fifoErr`, `breakLive` and `overrun` are all 0.
- R2: Entries leave in the order they entered. The head ports show the oldest entry's data byte and its parity, framing and break tags, and `fillLevel` counts stored entries up to 64.
- R3: A write while `full` is 1 is discarded and leaves the stored contents unchanged. It sets `overrun`, which stays set until a cycle with `ovrClr` high. A new discarded write in that same cycle takes precedence over the clear.
- R4: A pop strobe while the queue is empty has no effect.
- R5: `fifoErr` is 1 exactly while at least one stored entry has any of its three tags set. It drops in the cycle after the last such entry is popped.
- R6: A write and a pop in the same cycle on a queue that is neither empty nor full leave `fillLevel` unchanged. `fifoErr` then reflects the entry that left and the entry that arrived.
- R7: A break is detected on the tenth `bitTick` in an unbroken run of ticks that sample `serIn` low. A high level on `serIn` restarts the count.
- R8: Each break event writes exactly one entry, with data 0x00, break tag 1 and parity and framing tags 0, however long the line stays low.
- R9: `breakLive` rises together with the break entry's write and stays high until the cycle after `serIn` is seen high.
- R10: When a break entry and a `chrValid` character arrive in the same cycle, only the break entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chrValid | input | 1 | Receiver core has a finished character this cycle |
| chrData | input | 8 | Received character byte |
| chrParErr | input | 1 | Parity error tag for chrData |
| chrFrmErr | input | 1 | Framing error tag for chrData |
| serIn | input | 1 | Raw serial line level, high when idle |
| bitTick | input | 1 | One pulse per bit time |
| popReq | input | 1 | Host removes the head entry |
| ovrClr | input | 1 | Host clears the overrun flag |
| headData | output | 8 | Data byte of the oldest entry |
| headParErr | output | 1 | Parity tag of the oldest entry |
| headFrmErr | output | 1 | Framing tag of the oldest entry |
| headBrk | output | 1 | Break tag of the oldest entry |
| fillLevel | output | 7 | Number of stored entries |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds 64 entries |
| fifoErr | output | 1 | Some stored entry carries an error tag |
| breakLive | output | 1 | Line break currently in progress |
| overrun | output | 1 | Sticky: a write was discarded because the queue was full |

## Verification
The assertions check on every cycle that the count stays within 64 and that `fifoErr` never claims an error in an empty queue. They also check that a write into a full queue holds the count and sets `overrun`, that a clear drops `overrun`, that an idle-line pop on an empty queue changes nothing, that a same-cycle write and pop keep the count, and that `breakLive` falls once the line is high. The bench scenarios are needed for the data and tag ordering through all 64 entries and for the exact moment `fifoErr` clears as flagged entries leave. They also cover the tick at which a break is recognised, the restart after a glitch, the single zero-valued break entry, and its priority over a concurrent character.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              parErr;
    logic              frmErr;
    logic              brkTag;
  } rxq_entry_t;

  typedef struct packed {
    logic       push;
    logic       pop;
    rxq_entry_t wrEntry;
  } rxq_ctl_t;

  function automatic logic entryFlagged(input rxq_entry_t e);
    return e.parErr | e.frmErr | e.brkTag;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxq_ctl_t         ctl,
  output rxq_entry_t       headEntry,
  output logic [CNT_W-1:0] fillLevel,
  output logic             full,
  output logic             empty
);
  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= ctl.wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headEntry = mem[rdPtr];
  assign fillLevel = count;
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int FRAME_TICKS = 10,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LOW_W = $clog2(FRAME_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chrValid,
  input  logic [DATA_W-1:0] chrData,
  input  logic              chrParErr,
  input  logic              chrFrmErr,
  input  logic              serIn,
  input  logic              bitTick,
  input  logic              popReq,
  input  logic              ovrClr,
  input  logic              full,
  input  logic              empty,
  input  rxq_entry_t        headEntry,
  output rxq_ctl_t          ctl,
  output logic              fifoErr,
  output logic              breakLive,
  output logic              overrun
);
  logic [LOW_W-1:0] lowCnt;
  logic [CNT_W-1:0] errCnt;
  logic             brkFire;
  logic             wantPush;
  logic             addErr;
  logic             subErr;

  // break detector: counts ticks of a continuous low run, saturating at one frame
  assign brkFire = bitTick && !serIn && (lowCnt == LOW_W'(FRAME_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt    <= '0;
      breakLive <= 1'b0;
    end else if (serIn) begin
      lowCnt    <= '0;
      breakLive <= 1'b0;
    end else begin
      if (bitTick && lowCnt != LOW_W'(FRAME_TICKS)) lowCnt <= lowCnt + LOW_W'(1);
      if (brkFire) breakLive <= 1'b1;
    end
  end

  // write selection: a break entry wins over a concurrent character
  assign wantPush = brkFire || chrValid;

  always_comb begin
    ctl = '0;
    if (brkFire) begin
      ctl.wrEntry.data   = '0;
      ctl.wrEntry.brkTag = 1'b1;
    end else begin
      ctl.wrEntry.data   = chrData;
      ctl.wrEntry.parErr = chrParErr;
      ctl.wrEntry.frmErr = chrFrmErr;
    end
    ctl.push = wantPush && !full;
    ctl.pop  = popReq && !empty;
  end

  // count of flagged entries in the store
  assign addErr = ctl.push && entryFlagged(ctl.wrEntry);
  assign subErr = ctl.pop && entryFlagged(headEntry);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt <= '0;
    end else begin
      case ({addErr, subErr})
        2'b10:   errCnt <= errCnt + CNT_W'(1);
        2'b01:   errCnt <= errCnt - CNT_W'(1);
        default: errCnt <= errCnt;
      endcase
    end
  end

  assign fifoErr = (errCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)                 overrun <= 1'b0;
    else if (wantPush && full) overrun <= 1'b1;
    else if (ovrClr)           overrun <= 1'b0;
  end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int FRAME_TICKS = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chrValid,
  input  logic [7:0]       chrData,
  input  logic             chrParErr,
  input  logic             chrFrmErr,
  input  logic             serIn,
  input  logic             bitTick,
  input  logic             popReq,
  input  logic             ovrClr,
  output logic [7:0]       headData,
  output logic             headParErr,
  output logic             headFrmErr,
  output logic             headBrk,
  output logic [CNT_W-1:0] fillLevel,
  output logic             empty,
  output logic             full,
  output logic             fifoErr,
  output logic             breakLive,
  output logic             overrun
);
  rxq_ctl_t   ctl;
  rxq_entry_t headEntry;

  rxq_ctrl #(.DEPTH(DEPTH), .FRAME_TICKS(FRAME_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrData(chrData),
    .chrParErr(chrParErr), .chrFrmErr(chrFrmErr), .serIn(serIn),
    .bitTick(bitTick), .popReq(popReq), .ovrClr(ovrClr), .full(full),
    .empty(empty), .headEntry(headEntry), .ctl(ctl), .fifoErr(fifoErr),
    .breakLive(breakLive), .overrun(overrun)
  );

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .headEntry(headEntry),
    .fillLevel(fillLevel), .full(full), .empty(empty)
  );

  assign headData   = headEntry.data;
  assign headParErr = headEntry.parErr;
  assign headFrmErr = headEntry.frmErr;
  assign headBrk    = headEntry.brkTag;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             chrValid,
  input logic             serIn,
  input logic             popReq,
  input logic             ovrClr,
  input logic [CNT_W-1:0] fillLevel,
  input logic             empty,
  input logic             full,
  input logic             fifoErr,
  input logic             breakLive,
  input logic             overrun
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH));

  a_r5_err_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    fifoErr |-> !empty);

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (full && chrValid && !popReq) |=> ($stable(fillLevel) && overrun));

  a_r3_ovr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClr && !(full && (chrValid || !serIn))) |=> !overrun);

  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (empty && popReq && !chrValid && serIn) |=> empty);

  a_r6_push_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (chrValid && popReq && !empty && !full) |=> $stable(fillLevel));

  a_r9_break_release: assert property (@(posedge clk) disable iff (!rstN)
    (breakLive && serIn) |=> !breakLive);
endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .chrValid(chrValid), .serIn(serIn),
  .popReq(popReq), .ovrClr(ovrClr), .fillLevel(fillLevel), .empty(empty),
  .full(full), .fifoErr(fifoErr), .breakLive(breakLive), .overrun(overrun)
);

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chrValid = 1'b0;
  logic [7:0] chrData = '0;
  logic       chrParErr = 1'b0;
  logic       chrFrmErr = 1'b0;
  logic       serIn = 1'b1;
  logic       bitTick = 1'b0;
  logic       popReq = 1'b0;
  logic       ovrClr = 1'b0;
  logic [7:0] headData;
  logic       headParErr, headFrmErr, headBrk;
  logic [6:0] fillLevel;
  logic       empty, full, fifoErr, breakLive, overrun;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_top dut_i (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrData(chrData),
    .chrParErr(chrParErr), .chrFrmErr(chrFrmErr), .serIn(serIn),
    .bitTick(bitTick), .popReq(popReq), .ovrClr(ovrClr),
    .headData(headData), .headParErr(headParErr), .headFrmErr(headFrmErr),
    .headBrk(headBrk), .fillLevel(fillLevel), .empty(empty), .full(full),
    .fifoErr(fifoErr), .breakLive(breakLive), .overrun(overrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: inputs already set at a falling edge, results sampled at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chrValid = 1'b0; popReq = 1'b0; ovrClr = 1'b0; bitTick = 1'b0;
  endtask

  function automatic logic patPar(input int i); return (i % 7) == 3; endfunction
  function automatic logic patFrm(input int i); return (i % 11) == 5; endfunction
  function automatic int flaggedFrom(input int lo);
    int n = 0;
    for (int j = lo; j < DEPTH; j++) if (patPar(j) || patFrm(j)) n++;
    return n;
  endfunction

  task automatic drive(input logic v, input int d, input logic p, input logic f, input logic pop);
    chrValid = v; chrData = 8'(d); chrParErr = p; chrFrmErr = f; popReq = pop;
    step();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bitTick = 1'b1;
      step();
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 fill", fillLevel, 0);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 err", fifoErr, 0);
    check("R1 brk", breakLive, 0);
    check("R1 ovr", overrun, 0);

    // R4 pop on empty
    drive(0, 0, 0, 0, 1);
    check("R4 fill", fillLevel, 0);
    check("R4 empty", empty, 1);

    // R2 / R5 fill whole queue with a tag pattern
    for (int i = 0; i < DEPTH; i++) begin
      drive(1, i * 3 + 1, patPar(i), patFrm(i), 0);
      check("R2 fill", fillLevel, i + 1);
      check("R5 err on write", fifoErr, (flaggedFrom(0) - flaggedFrom(i + 1)) != 0);
    end
    check("R2 full", full, 1);

    // R3 overrun
    drive(1, 8'hEE, 1, 0, 0);
    check("R3 fill held", fillLevel, DEPTH);
    check("R3 ovr set", overrun, 1);
    check("R3 head kept", headData, 1);
    step();
    check("R3 ovr sticky", overrun, 1);
    ovrClr = 1'b1; step();
    check("R3 ovr cleared", overrun, 0);
    ovrClr = 1'b1; chrValid = 1'b1; step();
    check("R3 drop beats clear", overrun, 1);
    ovrClr = 1'b1; step();

    // R2 / R5 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 head data", headData, (i * 3 + 1) & 255);
      check("R2 head par", headParErr, patPar(i));
      check("R2 head frm", headFrmErr, patFrm(i));
      check("R5 err while draining", fifoErr, flaggedFrom(i) != 0);
      drive(0, 0, 0, 0, 1);
    end
    check("R5 err empty", fifoErr, 0);
    check("R2 empty", empty, 1);

    // R6 simultaneous write and pop
    drive(1, 8'h11, 1, 0, 0);
    check("R6 setup err", fifoErr, 1);
    drive(1, 8'h22, 0, 0, 1);
    check("R6 fill held", fillLevel, 1);
    check("R6 err cleared", fifoErr, 0);
    check("R6 head", headData, 8'h22);
    drive(1, 8'h33, 0, 1, 1);
    check("R6 err raised", fifoErr, 1);
    drive(1, 8'h44, 1, 1, 1);
    check("R6 err kept", fifoErr, 1);
    check("R6 fill kept", fillLevel, 1);
    drive(0, 0, 0, 0, 1);
    check("R6 drained", fifoErr, 0);

    // R7 glitch restarts the count
    serIn = 1'b0; ticks(5);
    serIn = 1'b1; step();
    serIn = 1'b0; ticks(9);
    check("R7 no early break", breakLive, 0);
    check("R7 no early entry", fillLevel, 0);
    // tenth tick plus a concurrent character (R10)
    bitTick = 1'b1; chrValid = 1'b1; chrData = 8'h5A; chrParErr = 1'b0; chrFrmErr = 1'b0;
    step();
    check("R7 break seen", breakLive, 1);
    check("R10 single entry", fillLevel, 1);
    check("R8 data", headData, 0);
    check("R8 brk tag", headBrk, 1);
    check("R8 par tag", headParErr, 0);
    check("R8 frm tag", headFrmErr, 0);
    check("R5 brk err", fifoErr, 1);
    ticks(20);
    check("R8 one per event", fillLevel, 1);
    check("R9 held low", breakLive, 1);
    serIn = 1'b1; step();
    check("R9 released", breakLive, 0);
    drive(0, 0, 0, 0, 1);
    check("R5 brk gone", fifoErr, 0);
    check("R2 empty end", empty, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule